// File: doc/BRIEF.md
# Level-Interrupt GPIO Controller

This block controls a bank of general-purpose pins. Software reaches it through a small 32-bit register port. The port writes on a single-cycle strobe and reads back combinationally. Through the port, software sets a data value and a drive-enable for each pin. It also reads the pin levels after the block has synchronized them.

Each line can raise an interrupt when it sits at a level that software chooses for that line. Any line found at its active level is latched into a status word. Software clears status bits by writing ones to them. If the line is still active at that point, the bit latches again straight away. A per-line enable word gates the single shared interrupt output, which stays high for as long as an enabled status bit is set.

One 32-bit register is storage only. The pin-routing logic outside this block reads it, and nothing inside the block uses it.

Top module: `gpio_lvl_ctrl`

## Requirements
- R1: After reset, every register reads 0, `pin_oe` and `pin_out` are 0, and `irq` is low.
- R2: Word offset 0x00 holds the drive data and 0x04 holds the drive enable. Both use bits [11:0], and bit n belongs to line n. `pin_oe` follows the enable register. `pin_out[n]` carries the data bit only while the enable bit is 1, and is 0 otherwise.
- R3: Offset 0x08 returns the pin levels after a two-flop synchronizer. A pin change made before rising edge k reads back after edge k+1. Writes to 0x08 have no effect.
- R4: Two 32-bit read/write polarity registers choose the active level of each line. Offset 0x10 serves lines 0..7 and offset 0x18 serves lines 8..11. The bit for line n is bit 4*(n mod 8). A value of 0 means active-high and 1 means active-low.
- R5: Status bit n (offset 0x0C, bits [11:0]) sets on the edge after line n's synchronized level matches its active level. This happens whether or not the line is enabled, and the bit stays set until it is cleared.
- R6: Writing to 0x0C clears each status bit whose write-data bit is 1 and leaves bits written with 0 unchanged. Writing 0x7FF clears lines 0..10 and leaves line 11.
- R7: A status bit that is cleared while its line is still at the active level reads 1 again on the next read.
- R8: Offset 0x14 holds the interrupt enable in bits [11:0], where 1 unmasks a line. `irq` is high exactly when some status bit and its enable bit are both 1.
- R9: Offset 0x1C is a 32-bit read/write register that does not change pins, status or `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Byte address; bits [4:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 12 | Pin levels, asynchronous |
| pin_out | output | 12 | Drive value per pin |
| pin_oe | output | 12 | Drive enable per pin |
| irq | output | 1 | Shared level interrupt |

## Verification
The bench goes after the following corner cases:
- Clearing a status bit while its pin is still active. A design that let the clear win would drop a live interrupt.
- Clearing with the 0x7FF mask. A design with a misplaced clear mask would wipe line 11 or leave line 10 set.
- Polarity bits at the ends of each type register: line 7 at bit 28 of 0x10, and lines 8 and 11 at bits 0 and 12 of 0x18. A wrong stride or register choice would latch the wrong line.
- A masked line that becomes active. A design that gated the latch rather than the output would lose that status.
- Writes to the input and pin-routing words. These must not disturb pins or status.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;
  localparam int REG_W        = 32;
  localparam int LINES_PER_TY = 8;
  localparam int POL_STRIDE   = 4;

  localparam logic [2:0] W_DOUT = 3'd0;
  localparam logic [2:0] W_DOE  = 3'd1;
  localparam logic [2:0] W_DIN  = 3'd2;
  localparam logic [2:0] W_STAT = 3'd3;
  localparam logic [2:0] W_TY0  = 3'd4;
  localparam logic [2:0] W_IEN  = 3'd5;
  localparam logic [2:0] W_TY1  = 3'd6;
  localparam logic [2:0] W_MUX  = 3'd7;

  // returns 1 when line n is configured active-low
  function automatic logic line_low_active(input logic [REG_W-1:0] ty0,
                                           input logic [REG_W-1:0] ty1,
                                           input int n);
    int pos;
    pos = POL_STRIDE * (n % LINES_PER_TY);
    if (n < LINES_PER_TY) return ty0[pos];
    return ty1[pos];
  endfunction

  // status after one edge: clear-by-one, then active lines set again
  function automatic logic stat_next(input logic cur, input logic ack, input logic act);
    return (cur & ~ack) | act;
  endfunction
endpackage

// File: rtl/gpio_lvl_sync.sv
module gpio_lvl_sync #(
  parameter int N      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  logic [N-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_lvl_status.sv
module gpio_lvl_status #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] act,
  input  logic [N-1:0] ack,
  output logic [N-1:0] status_q
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) status_q[i] <= 1'b0;
        else        status_q[i] <= gpio_lvl_pkg::stat_next(status_q[i], ack[i], act[i]);
    end
  endgenerate
endmodule

// File: rtl/gpio_lvl_regs.sv
module gpio_lvl_regs #(
  parameter int N  = 12,
  parameter int AW = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr,
  input  logic [AW-1:0]                  addr,
  input  logic [gpio_lvl_pkg::REG_W-1:0] wdata,
  input  logic [N-1:0]                   sync_in,
  input  logic [N-1:0]                   status_q,
  output logic [gpio_lvl_pkg::REG_W-1:0] rdata,
  output logic [N-1:0]                   dout_q,
  output logic [N-1:0]                   doe_q,
  output logic [N-1:0]                   ien_q,
  output logic [gpio_lvl_pkg::REG_W-1:0] ty0_q,
  output logic [gpio_lvl_pkg::REG_W-1:0] ty1_q,
  output logic [gpio_lvl_pkg::REG_W-1:0] mux_q,
  output logic [N-1:0]                   ack_mask
);
  import gpio_lvl_pkg::*;
  localparam int PAD = REG_W - N;

  logic [2:0] widx;
  logic       unused_lowaddr;
  assign widx           = addr[4:2];
  assign unused_lowaddr = ^{addr[1:0], wdata[REG_W-1:N]};

  function automatic logic [REG_W-1:0] widen(input logic [N-1:0] v);
    return {{PAD{1'b0}}, v};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      doe_q  <= '0;
      ien_q  <= '0;
      ty0_q  <= '0;
      ty1_q  <= '0;
      mux_q  <= '0;
    end else if (wr) begin
      case (widx)
        W_DOUT:  dout_q <= wdata[N-1:0];
        W_DOE:   doe_q  <= wdata[N-1:0];
        W_IEN:   ien_q  <= wdata[N-1:0];
        W_TY0:   ty0_q  <= wdata;
        W_TY1:   ty1_q  <= wdata;
        W_MUX:   mux_q  <= wdata;
        default: ;
      endcase
    end
  end

  assign ack_mask = (wr && widx == W_STAT) ? wdata[N-1:0] : '0;

  always_comb begin
    case (widx)
      W_DOUT:  rdata = widen(dout_q);
      W_DOE:   rdata = widen(doe_q);
      W_DIN:   rdata = widen(sync_in);
      W_STAT:  rdata = widen(status_q);
      W_TY0:   rdata = ty0_q;
      W_IEN:   rdata = widen(ien_q);
      W_TY1:   rdata = ty1_q;
      default: rdata = mux_q;
    endcase
  end
endmodule

// File: rtl/gpio_lvl_ctrl.sv
module gpio_lvl_ctrl #(
  parameter int N  = 12,
  parameter int AW = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]  bus_wdata,
  output logic [31:0]  bus_rdata,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe,
  output logic         irq
);
  import gpio_lvl_pkg::*;

  logic [N-1:0]     sync_in, pol, act_lvl, status_q, ack_mask;
  logic [N-1:0]     dout_q, doe_q, ien_q;
  logic [REG_W-1:0] ty0_q, ty1_q, mux_q;
  logic             unused_mux;
  assign unused_mux = ^mux_q;

  gpio_lvl_sync #(.N(N), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(sync_in));

  gpio_lvl_regs #(.N(N), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .sync_in(sync_in), .status_q(status_q), .rdata(bus_rdata),
    .dout_q(dout_q), .doe_q(doe_q), .ien_q(ien_q),
    .ty0_q(ty0_q), .ty1_q(ty1_q), .mux_q(mux_q), .ack_mask(ack_mask));

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_pol
      assign pol[i] = line_low_active(ty0_q, ty1_q, i);
    end
  endgenerate

  assign act_lvl = sync_in ^ pol;

  gpio_lvl_status #(.N(N)) u_stat (
    .clk(clk), .rst_n(rst_n), .act(act_lvl), .ack(ack_mask), .status_q(status_q));

  assign pin_oe  = doe_q;
  assign pin_out = dout_q & doe_q;
  assign irq     = |(status_q & ien_q);
endmodule

// File: rtl/gpio_lvl_chk.sv
module gpio_lvl_chk #(
  parameter int N = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] act_lvl,
  input logic [N-1:0] ack_mask,
  input logic [N-1:0] status,
  input logic [N-1:0] en,
  input logic [N-1:0] pin_out,
  input logic [N-1:0] pin_oe,
  input logic         irq
);
  a_r2_no_drive_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  a_r5_active_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (|act_lvl) |=> ((status & $past(act_lvl)) == $past(act_lvl)));

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack_mask & ~act_lvl)) |=> ((status & $past(ack_mask & ~act_lvl)) == '0));

  a_r6_unacked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & $past(status & ~ack_mask)) == $past(status & ~ack_mask)));

  a_r7_relatch: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack_mask & act_lvl)) |=> ((status & $past(ack_mask & act_lvl)) == $past(ack_mask & act_lvl)));

  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);
endmodule

bind gpio_lvl_ctrl gpio_lvl_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .act_lvl(act_lvl), .ack_mask(ack_mask),
  .status(status_q), .en(ien_q), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

// File: tb/sim_gpio_lvl_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_lvl_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 12;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] pin_in = '0, pin_out, pin_oe;
  logic irq;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_lvl_ctrl u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  // reference state
  logic [N-1:0] m_s1, m_s2, m_st, m_do, m_oe, m_en;
  logic [31:0]  m_t0, m_t1, m_mx;

  function automatic logic [N-1:0] want_active(input logic [N-1:0] lv, input logic [31:0] a, input logic [31:0] b);
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) begin
      logic lowsel;
      lowsel = (k >= 8) ? b[(k-8)*4] : a[k*4];
      r[k] = lowsel ? ~lv[k] : lv[k];
    end
    return r;
  endfunction

  function automatic logic [31:0] want_read(input logic [4:0] a);
    case (a[4:2])
      3'd0: return {20'd0, m_do};
      3'd1: return {20'd0, m_oe};
      3'd2: return {20'd0, m_s2};
      3'd3: return {20'd0, m_st};
      3'd4: return m_t0;
      3'd5: return {20'd0, m_en};
      3'd6: return m_t1;
      default: return m_mx;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_st <= '0; m_do <= '0; m_oe <= '0; m_en <= '0;
      m_t0 <= '0; m_t1 <= '0; m_mx <= '0;
    end else begin
      m_s1 <= pin_in; m_s2 <= m_s1;
      m_st <= (m_st & ~((bus_wr && bus_addr[4:2] == 3'd3) ? bus_wdata[N-1:0] : '0))
              | want_active(m_s2, m_t0, m_t1);
      if (bus_wr) case (bus_addr[4:2])
        3'd0: m_do <= bus_wdata[N-1:0];
        3'd1: m_oe <= bus_wdata[N-1:0];
        3'd4: m_t0 <= bus_wdata;
        3'd5: m_en <= bus_wdata[N-1:0];
        3'd6: m_t1 <= bus_wdata;
        3'd7: m_mx <= bus_wdata;
        default: ;
      endcase
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input string req, input logic [4:0] a);
    @(negedge clk); bus_addr = a; #1;
    chk(req, bus_rdata, want_read(a));
  endtask

  task automatic rd_const(input string req, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk); bus_addr = a; #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic outs(input string req);
    #1;
    chk({req, " irq"}, {31'd0, irq}, {31'd0, |(m_st & m_en)});
    chk({req, " pins"}, {20'd0, pin_out}, {20'd0, m_do & m_oe});
    chk({req, " oe"}, {20'd0, pin_oe}, {20'd0, m_oe});
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int w = 0; w < 8; w++) rd_const("R1 reset regs", 5'(w * 4), 32'd0);
    outs("R1 reset");

    // R2 data and enable
    wr(5'h00, 32'h0000_0F5A); wr(5'h04, 32'h0000_00FF);
    @(negedge clk); #1; chk("R2 masked drive", {20'd0, pin_out}, 32'h05A);
    rd("R2 oe readback", 5'h04);

    // R3 sync latency and read-only input
    @(negedge clk); pin_in = 12'hA51;
    @(negedge clk); #1; bus_addr = 5'h08; #1; chk("R3 one edge", bus_rdata, 32'h0);
    @(negedge clk); #1; chk("R3 two edges", bus_rdata, 32'hA51);
    wr(5'h08, 32'hFFFF_FFFF); rd_const("R3 write ignored", 5'h08, 32'hA51);

    // R5 masked line still latches, irq stays low (R8)
    rd_const("R5 latched while masked", 5'h0C, 32'hA51);
    #1; chk("R8 masked irq", {31'd0, irq}, 32'd0);
    @(negedge clk); pin_in = '0; wait_cyc(3);

    // R6 0x7FF mask leaves line 11
    wr(5'h0C, 32'h0000_07FF);
    rd_const("R6 mask 7FF", 5'h0C, 32'h800);
    wr(5'h0C, 32'h0000_0800);
    rd_const("R6 line 11 clear", 5'h0C, 32'h0);

    // R7 clear while active re-latches
    @(negedge clk); pin_in = 12'h008; wait_cyc(4);
    wr(5'h0C, 32'h0000_0008);
    rd_const("R7 relatch", 5'h0C, 32'h008);
    wr(5'h14, 32'h0000_0008); outs("R8 enabled irq");
    #1; chk("R8 irq high", {31'd0, irq}, 32'd1);
    @(negedge clk); pin_in = '0; wait_cyc(3);
    wr(5'h0C, 32'h0000_0008);
    rd_const("R6 clear inactive", 5'h0C, 32'h0);

    // R4 polarity positions: line 7 (bit 28, reg 0x10), lines 8 and 11 (bits 0 and 12, reg 0x18)
    wr(5'h10, 32'h1000_0000); wr(5'h18, 32'h0000_1001);
    wait_cyc(1);
    wr(5'h0C, 32'h0000_0FFF);
    rd_const("R4 active-low lines", 5'h0C, 32'h980);
    @(negedge clk); pin_in = 12'h980; wait_cyc(3);
    wr(5'h0C, 32'h0000_0FFF);
    rd_const("R4 high clears low-active", 5'h0C, 32'h0);

    // R9 mux register storage only
    wr(5'h1C, 32'hDEAD_BEEF);
    rd_const("R9 mux readback", 5'h1C, 32'hDEAD_BEEF);
    rd("R9 status unchanged", 5'h0C);
    outs("R9 no effect");

    // random mix
    for (int it = 0; it < 600; it++) begin
      int op;
      op = int'($urandom % 4);
      case (op)
        0: wr(5'($urandom % 8) << 2, $urandom);
        1: begin @(negedge clk); pin_in = N'($urandom); end
        2: rd("R2-R9 random read", 5'($urandom % 32));
        default: wr(5'h0C, $urandom);
      endcase
      outs("R8 random");
    end
    finish_run();
  end
endmodule